// File: doc/BRIEF.md
# Raster dot, line and frame timing generator

This block keeps the beam position for a raster video unit. Each cycle on which the dot enable is high advances a dot counter; the end of a line advances the line counter, and the end of the last line wraps to line 0 and advances the frame counter. The length of a frame depends on the interlace mode and on the parity of the frame counter. One line of every other progressive frame is one dot shorter than the others.

Around the counters it produces the timing events the rest of the video and memory system needs. It raises a vertical-blank flag and, when enabled, a one-cycle interrupt request on entry to vertical blank. It gives one pulse per visible line that starts per-line transfer work. It also asks once per line for a memory refresh stall of 40 master cycles, placed where the master clock sits on an 8-cycle boundary.

A region state machine has two states: `REG_ACTIVE` (visible lines) and `REG_VBLANK`. The transition `ACTIVE->VBLANK` happens when the counter steps from line VBLANK_LINE-1 to VBLANK_LINE. The transition `VBLANK->ACTIVE` happens on frame wrap. A refresh state machine also has two states, `REF_ARMED` and `REF_SPENT`. The transition `ARMED->SPENT` happens when a refresh request is issued. The transition `SPENT->ARMED` happens at the end of each line.

Top module: `raster_timer`

## Requirements
- R1: `dot` advances by one on each clock with `dot_en` high and holds otherwise. After the last dot of a line it returns to 0 and `line` increments. A normal line has DOTS dots (0..DOTS-1).
- R2: With `interlace` low, a frame has LINES lines (0..LINES-1).
- R3: With `interlace` high, a frame whose counter is odd has LINES lines, and a frame whose counter is even has LINES+1 lines.
- R4: With `interlace` low and bit 0 of `frame` set, line SHORT_LINE ends after dot DOTS-2. With `interlace` high, no line is shortened.
- R5: At frame wrap, `line` becomes 0, `frame` increments modulo 2^FW and `nmi_flag` clears.
- R6: When `line` steps to VBLANK_LINE, `nmi_flag` sets. `nmi_req` pulses for one cycle at the same moment, but only if `nmi_enable` was high on that dot.
- R7: `refresh_req` pulses for one cycle after a dot-enabled clock on which `dot` is REFRESH_DOT or REFRESH_DOT+1 and `mclk_phase` is 0. There is at most one pulse per line, and there is none when the phase is nonzero on both of those dots.
- R8: `hdma_trig` pulses for one cycle after a dot-enabled clock on which `dot` is HDMA_DOT and `line` is below VBLANK_LINE.
- R9: While `rst_n` is low, all counters, flags and pulses are 0. The region state is `REG_ACTIVE`, and frame 0 counts as even.
- R10: All outputs are registered. A counter change or pulse caused by a dot-enabled clock edge is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| dot_en | input | 1 | one dot elapses on this clock |
| interlace | input | 1 | interlaced frame mode |
| nmi_enable | input | 1 | allow the vertical-blank interrupt request |
| mclk_phase | input | 3 | master clock modulo 8 |
| dot | output | DW (9) | dot within the line |
| line | output | LW (9) | line within the frame |
| frame | output | FW (8) | frame counter |
| nmi_flag | output | 1 | vertical-blank flag |
| nmi_req | output | 1 | one-cycle interrupt request |
| hdma_trig | output | 1 | one-cycle per-line transfer start |
| refresh_req | output | 1 | one-cycle request for a 40-master-cycle stall |

## Verification
The hardest cases are the extra line of an even interlaced frame and the short line of an odd progressive frame. Both depend on the frame parity at the moment the last line ends, so they need long runs, and the mode may change between frames. The bench uses small parameters so that a frame is a few hundred dots. It switches `interlace` at random across many frames and also runs directed spans in each mode. A refresh request at the second allowed dot, after a miss at the first, happens only when the phase is nonzero and then zero on consecutive enabled dots. Random phases on every cycle reach it often, and a directed line forces the phase nonzero on both dots.

// File: rtl/raster_pkg.sv
package raster_pkg;
    typedef enum logic {
        REG_ACTIVE = 1'b0,
        REG_VBLANK = 1'b1
    } region_e;

    typedef enum logic {
        REF_ARMED = 1'b0,
        REF_SPENT = 1'b1
    } refresh_e;
endpackage

// File: rtl/raster_dot_ctr.sv
module raster_dot_ctr #(
    parameter int DOTS = 340,
    parameter int DW   = $clog2(DOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dot_en,
    input  logic          short_line,
    output logic [DW-1:0] dot,
    output logic          line_end
);
    localparam logic [DW-1:0] LAST_FULL  = DW'(DOTS - 1);
    localparam logic [DW-1:0] LAST_SHORT = DW'(DOTS - 2);

    logic [DW-1:0] last_dot;

    always_comb begin
        last_dot = short_line ? LAST_SHORT : LAST_FULL;
        line_end = dot_en && (dot == last_dot);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dot <= '0;
        end else if (dot_en) begin
            dot <= line_end ? '0 : dot + 1'b1;
        end
    end
endmodule

// File: rtl/raster_line_ctr.sv
module raster_line_ctr
    import raster_pkg::*;
#(
    parameter int LINES       = 262,
    parameter int VBLANK_LINE = 225,
    parameter int LW          = $clog2(LINES + 1),
    parameter int FW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_end,
    input  logic          interlace,
    input  logic          nmi_enable,
    output logic [LW-1:0] line,
    output logic [FW-1:0] frame,
    output region_e       region,
    output logic          nmi_flag,
    output logic          nmi_req
);
    localparam logic [LW-1:0] PRE_VB     = LW'(VBLANK_LINE - 1);
    localparam logic [LW-1:0] LAST_SHORT = LW'(LINES - 1);
    localparam logic [LW-1:0] LAST_LONG  = LW'(LINES);

    region_e       region_d;
    logic [LW-1:0] frame_last;
    logic          frame_end;
    logic          enter_vb;

    always_comb begin
        frame_last = (!interlace || frame[0]) ? LAST_SHORT : LAST_LONG;
        frame_end  = line_end && (line == frame_last);
        enter_vb   = line_end && (line == PRE_VB);
    end

    always_comb begin
        region_d = region;
        unique case (region)
            REG_ACTIVE: if (enter_vb)  region_d = REG_VBLANK;
            REG_VBLANK: if (frame_end) region_d = REG_ACTIVE;
            default:                   region_d = REG_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) region <= REG_ACTIVE;
        else        region <= region_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line     <= '0;
            frame    <= '0;
            nmi_flag <= 1'b0;
            nmi_req  <= 1'b0;
        end else begin
            nmi_req <= 1'b0;
            if (frame_end) begin
                line     <= '0;
                frame    <= frame + 1'b1;
                nmi_flag <= 1'b0;
            end else if (line_end) begin
                line <= line + 1'b1;
                if (enter_vb) begin
                    nmi_flag <= 1'b1;
                    nmi_req  <= nmi_enable;
                end
            end
        end
    end
endmodule

// File: rtl/raster_refresh.sv
module raster_refresh
    import raster_pkg::*;
#(
    parameter int REFRESH_DOT = 134,
    parameter int DW          = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dot_en,
    input  logic          line_end,
    input  logic [DW-1:0] dot,
    input  logic [2:0]    mclk_phase,
    output logic          refresh_req
);
    localparam logic [DW-1:0] RD0 = DW'(REFRESH_DOT);
    localparam logic [DW-1:0] RD1 = DW'(REFRESH_DOT + 1);

    refresh_e state, state_d;
    logic     fire;

    always_comb begin
        fire = dot_en && (state == REF_ARMED) &&
               ((dot == RD0) || (dot == RD1)) && (mclk_phase == 3'd0);
        state_d = state;
        unique case (state)
            REF_ARMED: if (fire)     state_d = REF_SPENT;
            REF_SPENT: if (line_end) state_d = REF_ARMED;
            default:                 state_d = REF_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= REF_ARMED;
        else        state <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) refresh_req <= 1'b0;
        else        refresh_req <= fire;
    end
endmodule

// File: rtl/raster_timer.sv
module raster_timer
    import raster_pkg::*;
#(
    parameter int DOTS        = 340,
    parameter int LINES       = 262,
    parameter int VBLANK_LINE = 225,
    parameter int SHORT_LINE  = 240,
    parameter int REFRESH_DOT = 134,
    parameter int HDMA_DOT    = 278,
    parameter int FW          = 8,
    parameter int DW          = $clog2(DOTS),
    parameter int LW          = $clog2(LINES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dot_en,
    input  logic          interlace,
    input  logic          nmi_enable,
    input  logic [2:0]    mclk_phase,
    output logic [DW-1:0] dot,
    output logic [LW-1:0] line,
    output logic [FW-1:0] frame,
    output logic          nmi_flag,
    output logic          nmi_req,
    output logic          hdma_trig,
    output logic          refresh_req
);
    localparam logic [LW-1:0] SHORT_L = LW'(SHORT_LINE);
    localparam logic [DW-1:0] HD      = DW'(HDMA_DOT);

    logic    short_line;
    logic    line_end;
    region_e region;

    assign short_line = !interlace && frame[0] && (line == SHORT_L);

    raster_dot_ctr #(.DOTS(DOTS), .DW(DW)) u_dot (
        .clk(clk), .rst_n(rst_n), .dot_en(dot_en),
        .short_line(short_line), .dot(dot), .line_end(line_end)
    );

    raster_line_ctr #(.LINES(LINES), .VBLANK_LINE(VBLANK_LINE), .LW(LW), .FW(FW)) u_line (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .interlace(interlace),
        .nmi_enable(nmi_enable), .line(line), .frame(frame), .region(region),
        .nmi_flag(nmi_flag), .nmi_req(nmi_req)
    );

    raster_refresh #(.REFRESH_DOT(REFRESH_DOT), .DW(DW)) u_ref (
        .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .line_end(line_end),
        .dot(dot), .mclk_phase(mclk_phase), .refresh_req(refresh_req)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) hdma_trig <= 1'b0;
        else        hdma_trig <= dot_en && (region == REG_ACTIVE) && (dot == HD);
    end
endmodule

// File: rtl/raster_timer_chk.sv
module raster_timer_chk #(
    parameter int DOTS        = 340,
    parameter int LINES       = 262,
    parameter int VBLANK_LINE = 225,
    parameter int FW          = 8,
    parameter int DW          = 9,
    parameter int LW          = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dot_en,
    input logic          nmi_enable,
    input logic [2:0]    mclk_phase,
    input logic [DW-1:0] dot,
    input logic [LW-1:0] line,
    input logic [FW-1:0] frame,
    input logic          nmi_flag,
    input logic          nmi_req,
    input logic          hdma_trig,
    input logic          refresh_req
);
    logic [LW-1:0] line_q;
    logic          seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            seen   <= 1'b0;
        end else begin
            line_q <= line;
            if (line != line_q) seen <= refresh_req;
            else if (refresh_req) seen <= 1'b1;
        end
    end

    a_r1_dot_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(dot) < DOTS);
    a_r1_dot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dot_en |=> $stable(dot));
    a_r3_line_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(line) <= LINES);
    a_r5_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame) |-> (line == '0) && !nmi_flag);
    a_r6_flag_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_flag) |-> 32'(line) == VBLANK_LINE);
    a_r6_req_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> nmi_flag && $past(nmi_enable));
    a_r7_phase_zero: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |-> $past(mclk_phase) == 3'd0 && $past(dot_en));
    a_r7_one_per_line: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req && (line == line_q) |-> !seen);
    a_r8_hdma_visible: assert property (@(posedge clk) disable iff (!rst_n)
        hdma_trig |-> 32'(line) < VBLANK_LINE);
endmodule

bind raster_timer raster_timer_chk #(
    .DOTS(DOTS), .LINES(LINES), .VBLANK_LINE(VBLANK_LINE),
    .FW(FW), .DW(DW), .LW(LW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .nmi_enable(nmi_enable),
    .mclk_phase(mclk_phase), .dot(dot), .line(line), .frame(frame),
    .nmi_flag(nmi_flag), .nmi_req(nmi_req), .hdma_trig(hdma_trig),
    .refresh_req(refresh_req)
);

// File: tb/raster_timer_bench.sv
`timescale 1ns/1ps
module raster_timer_bench;
    localparam int D  = 20;
    localparam int L  = 12;
    localparam int VB = 8;
    localparam int SL = 9;
    localparam int RD = 6;
    localparam int HD = 15;
    localparam int FW = 4;
    localparam int DW = $clog2(D);
    localparam int LW = $clog2(L + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dot_en = 1'b0, interlace = 1'b0, nmi_enable = 1'b0;
    logic [2:0]    mclk_phase = 3'd0;
    logic [DW-1:0] dot;
    logic [LW-1:0] line;
    logic [FW-1:0] frame;
    logic          nmi_flag, nmi_req, hdma_trig, refresh_req;

    int errors = 0, checks = 0;
    bit done = 0;

    int m_dot, m_line, m_frame;
    bit m_flag, m_spent, e_nmi, e_hdma, e_ref;

    always #2 clk = ~clk;

    raster_timer #(.DOTS(D), .LINES(L), .VBLANK_LINE(VB), .SHORT_LINE(SL),
                   .REFRESH_DOT(RD), .HDMA_DOT(HD), .FW(FW)) u_raster_timer (
        .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .interlace(interlace),
        .nmi_enable(nmi_enable), .mclk_phase(mclk_phase), .dot(dot), .line(line),
        .frame(frame), .nmi_flag(nmi_flag), .nmi_req(nmi_req),
        .hdma_trig(hdma_trig), .refresh_req(refresh_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (line %0d frame %0d)",
                     req, act, exp, m_line, m_frame);
        end
    endtask

    function automatic int last_dot(bit il);
        return (!il && m_frame[0] && m_line == SL) ? D - 2 : D - 1;
    endfunction

    function automatic int last_line(bit il);
        return (!il || m_frame[0]) ? L - 1 : L;
    endfunction

    task automatic model(input bit en, input bit il, input bit ne, input bit [2:0] ph);
        e_hdma = en && (m_line < VB) && (m_dot == HD);
        e_ref  = en && !m_spent && (m_dot == RD || m_dot == RD + 1) && (ph == 0);
        e_nmi  = 0;
        if (en) begin
            if (e_ref) m_spent = 1;
            if (m_dot == last_dot(il)) begin
                m_dot = 0;
                m_spent = 0;
                if (m_line == last_line(il)) begin
                    m_line = 0;
                    m_frame = (m_frame + 1) % (1 << FW);
                    m_flag = 0;
                end else begin
                    m_line++;
                    if (m_line == VB) begin
                        m_flag = 1;
                        e_nmi = ne;
                    end
                end
            end else begin
                m_dot++;
            end
        end
    endtask

    task automatic step(input bit en, input bit il, input bit ne, input bit [2:0] ph);
        @(negedge clk);
        dot_en = en; interlace = il; nmi_enable = ne; mclk_phase = ph;
        @(posedge clk);
        #1;
        model(en, il, ne, ph);
        chk("R1/R4 dot", int'(dot), m_dot);
        chk("R2/R3 line", int'(line), m_line);
        chk("R5 frame", int'(frame), m_frame);
        chk("R6 nmi_flag", int'(nmi_flag), int'(m_flag));
        chk("R6 nmi_req", int'(nmi_req), int'(e_nmi));
        chk("R7 refresh_req", int'(refresh_req), int'(e_ref));
        chk("R8 hdma_trig", int'(hdma_trig), int'(e_hdma));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_dot = 0; m_line = 0; m_frame = 0; m_flag = 0; m_spent = 0;
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        chk("R9 dot", int'(dot), 0);
        chk("R9 line", int'(line), 0);
        chk("R9 frame", int'(frame), 0);
        chk("R9 flags", int'({nmi_flag, nmi_req, hdma_trig, refresh_req}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R2 R4 progressive frames, full-rate dots, phase zero
        for (int i = 0; i < 3 * D * L; i++) step(1'b1, 1'b0, 1'b1, 3'd0);
        // R3 interlaced frames, NMI disabled
        for (int i = 0; i < 3 * D * (L + 1); i++) step(1'b1, 1'b1, 1'b0, 3'd0);
        // R7 phase nonzero on every dot of one line: no refresh
        for (int i = 0; i < D; i++) step(1'b1, 1'b1, 1'b1, 3'd4);
        // R10 idle cycles: nothing moves
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 1'b1, 3'd0);
        // random mix: mode changes per frame span, gaps in dot_en
        for (int seg = 0; seg < 40; seg++) begin
            bit il = 1'($urandom % 2);
            for (int i = 0; i < 600; i++)
                step(($urandom % 4) != 0, il, 1'($urandom % 2), 3'($urandom % 8));
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule